// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the SDRAM command pins from reset until the memory is usable, and after that it keeps the array refreshed. After reset it holds clock enable and every data-mask line high and sends NOP for a programmable pause. It then precharges all banks, sends a fixed number of auto-refresh commands (eight by default) and loads the mode register with a parameter word. At that point it raises `ready`.

Once initialised, an interval counter restarts on every REF the block issues. When the interval runs out, the counter raises `ref_req`, and the request stays up until the surrounding controller grants it. On a grant the block sends precharge-all and then REF, and keeps `ready` low until the refresh row cycle has elapsed. Every delay is given in picoseconds and converted to clock cycles at elaboration time by rounding up.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is high the pins show NOP, `cke` is 1, every `dqm` bit is 1, and `ready` and `ref_req` are 0.
- R2: `cke` stays 1 at all times. All `dqm` bits stay 1 until the cycle in which `ready` first rises, and from that cycle on they are all 0.
- R3: After reset is released, exactly PAUSE_CYC cycles of NOP are sent. In the next cycle, precharge-all appears, with addr bit 10 set and every other addr and ba bit 0.
- R4: Exactly INIT_REFS (8) REF commands follow the initial precharge-all. Consecutive REFs are TRC_CYC cycles apart.
- R5: MRS appears TRC_CYC cycles after the last initial REF, with ba and addr[11:10] zero and addr[9:0] equal to MODE_WORD.
- R6: `ready` rises exactly TMRD_CYC cycles after MRS. While `ready` is 1 the pins show NOP.
- R7: A picosecond limit becomes a cycle count by ceiling division by the clock period, with a minimum of 1. At a 4 ns clock, 67.5 ns gives 17 cycles and 20 ns gives 5. Precharge-all to the following REF is TRP_CYC cycles.
- R8: `ref_req` rises exactly REFI_CYC cycles after the most recent REF on the pins, including the initial REFs. It stays 1 until it is granted.
- R9: When `ref_grant` is 1 at an edge where `ref_req` and `ready` are 1, precharge-all appears in the following cycle and `ref_req` and `ready` fall in that same cycle. REF follows TRP_CYC cycles later, and `ready` returns TRC_CYC cycles after that REF.
- R10: `ref_grant` while `ref_req` is 0 has no effect. No command is sent and `ready` stays 1.
- R11: Command encodings on {cs_n, ras_n, cas_n, we_n} are: NOP 0111, precharge 0010, REF 0001, MRS 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant | input | 1 | Controller permits a pending refresh |
| ready | output | 1 | Initialised and no refresh in progress |
| ref_req | output | 1 | Refresh due, held until granted |
| cke | output | 1 | Clock enable to memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BW | Bank address |
| addr | output | AW | Address bus |
| dqm | output | DW | Data mask lines |

## Verification
The full power-up sequence is run at a 4 ns clock. At that period the precharge gap is an exact multiple of the clock and the row-cycle gap needs rounding up, so a truncating conversion shows up as a wrong spacing. For refresh, the grant is tried three ways. A grant pulse before any request must do nothing. A late grant against a pending request shows that the request is held and that the counter restarts from the REF, not from the request. A grant held high in advance shows the one-cycle response and that the request clears on acceptance.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PALL = 2'd1,
    CMD_REF  = 2'd2,
    CMD_MRS  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE    = 3'd0,
    ST_INIT_REF = 3'd1,
    ST_MRS      = 3'd2,
    ST_MRS_WAIT = 3'd3,
    ST_IDLE     = 3'd4,
    ST_RF_REF   = 3'd5,
    ST_RF_WAIT  = 3'd6
  } seq_state_e;

  // ceiling division of a picosecond limit by the clock period, at least 1
  function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                               input int unsigned clk_ps);
    longint unsigned c;
    c = (64'(t_ps) + 64'(clk_ps) - 64'd1) / 64'(clk_ps);
    if (c == 64'd0) c = 64'd1;
    return c[31:0];
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= INIT;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // a new command may only start once the previous gap has run out
  assert_load_expired_R4: assert property (@(posedge clk) disable iff (rst)
    load |-> done);

endmodule

// File: rtl/sdram_ref_interval.sv
module sdram_ref_interval #(
  parameter int unsigned W      = 12,
  parameter logic [W-1:0] RELOAD = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic allow,
  input  logic clear,
  output logic req
);

  logic [W-1:0] cnt;
  logic         started;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= RELOAD;
      started <= 1'b0;
      req     <= 1'b0;
    end else begin
      if (reload) begin
        cnt     <= RELOAD;
        started <= 1'b1;
      end else if (started && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (clear)
        req <= 1'b0;
      else if (started && allow && cnt == '0 && !reload)
        req <= 1'b1;
    end
  end

  // a pending request is only withdrawn by its grant
  assert_req_until_grant_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> $past(clear));

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_seq_pkg::*;
#(
  parameter int unsigned AW        = 12,
  parameter int unsigned BW        = 2,
  parameter int unsigned DW        = 4,
  parameter logic [9:0]  MODE_WORD = 10'h032
) (
  input  logic          clk,
  input  logic          rst,
  input  cmd_e          cmd,
  input  logic          dqm_release,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [BW-1:0] ba,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dqm
);

  localparam int unsigned AP_BIT = 10;
  localparam logic [3:0] PIN_NOP = 4'b0111;
  localparam logic [3:0] PIN_PRE = 4'b0010;
  localparam logic [3:0] PIN_REF = 4'b0001;
  localparam logic [3:0] PIN_MRS = 4'b0000;

  logic [3:0]    code_nx;
  logic [AW-1:0] addr_nx;

  always_comb begin
    addr_nx = '0;
    code_nx = PIN_NOP;
    unique case (cmd)
      CMD_PALL: begin
        code_nx         = PIN_PRE;
        addr_nx[AP_BIT] = 1'b1;
      end
      CMD_REF: code_nx = PIN_REF;
      CMD_MRS: begin
        code_nx      = PIN_MRS;
        addr_nx[9:0] = MODE_WORD;
      end
      default: code_nx = PIN_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= PIN_NOP;
      addr <= '0;
      ba   <= '0;
      cke  <= 1'b1;
      dqm  <= '1;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= code_nx;
      addr <= addr_nx;
      ba   <= '0;
      cke  <= 1'b1;
      if (dqm_release) dqm <= '0;
    end
  end

  assert_mrs_fields_R5: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == PIN_MRS) |->
      (ba == '0 && addr[AW-1:AP_BIT] == '0 && addr[9:0] == MODE_WORD));

  assert_pall_flag_R3: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == PIN_PRE) |-> (addr[AP_BIT] && ba == '0));

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 7500,
  parameter int unsigned PAUSE_PS      = 200_000_000,
  parameter int unsigned TRC_PS        = 67_500,
  parameter int unsigned TRP_PS        = 20_000,
  parameter int unsigned REFI_PS       = 15_000_000,
  parameter int unsigned TMRD_CYC      = 2,
  parameter int unsigned INIT_REFS     = 8,
  parameter int unsigned AW            = 12,
  parameter int unsigned BW            = 2,
  parameter int unsigned DW            = 4,
  parameter logic [9:0]  MODE_WORD     = 10'h032
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_grant,
  output logic          ready,
  output logic          ref_req,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [BW-1:0] ba,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dqm
);

  localparam int unsigned PAUSE_CYC = ps_to_cycles(PAUSE_PS, CLK_PERIOD_PS);
  localparam int unsigned TRC_CYC   = ps_to_cycles(TRC_PS, CLK_PERIOD_PS);
  localparam int unsigned TRP_CYC   = ps_to_cycles(TRP_PS, CLK_PERIOD_PS);
  localparam int unsigned REFI_CYC  = ps_to_cycles(REFI_PS, CLK_PERIOD_PS);
  localparam int unsigned MRD_CYC   = (TMRD_CYC == 0) ? 1 : TMRD_CYC;
  localparam int unsigned GAP_A     = (TRC_CYC > TRP_CYC) ? TRC_CYC : TRP_CYC;
  localparam int unsigned GAP_B     = (GAP_A > MRD_CYC) ? GAP_A : MRD_CYC;
  localparam int unsigned GAP_MAX   = (PAUSE_CYC > GAP_B) ? PAUSE_CYC : GAP_B;
  localparam int unsigned TW        = $clog2(GAP_MAX + 1);
  localparam int unsigned IW        = $clog2(REFI_CYC + 1);
  localparam int unsigned CW        = $clog2(INIT_REFS + 1);

  seq_state_e    st, st_nx;
  cmd_e          cmd_nx;
  logic [CW-1:0] ref_cnt, ref_cnt_nx;
  logic          ready_nx, init_finish, grant_ok, ref_issue;
  logic          gap_load, gap_done;
  logic [TW-1:0] gap_val;

  always_comb begin
    st_nx       = st;
    cmd_nx      = CMD_NOP;
    ref_cnt_nx  = ref_cnt;
    ready_nx    = ready;
    init_finish = 1'b0;
    grant_ok    = 1'b0;
    ref_issue   = 1'b0;
    gap_load    = 1'b0;
    gap_val     = '0;
    unique case (st)
      ST_PAUSE: if (gap_done) begin
        cmd_nx   = CMD_PALL;
        gap_load = 1'b1;
        gap_val  = TW'(TRP_CYC - 1);
        st_nx    = ST_INIT_REF;
      end
      ST_INIT_REF: if (gap_done) begin
        cmd_nx     = CMD_REF;
        ref_issue  = 1'b1;
        gap_load   = 1'b1;
        gap_val    = TW'(TRC_CYC - 1);
        ref_cnt_nx = ref_cnt + 1'b1;
        if (ref_cnt == CW'(INIT_REFS - 1)) st_nx = ST_MRS;
      end
      ST_MRS: if (gap_done) begin
        cmd_nx   = CMD_MRS;
        gap_load = 1'b1;
        gap_val  = TW'(MRD_CYC - 1);
        st_nx    = ST_MRS_WAIT;
      end
      ST_MRS_WAIT: if (gap_done) begin
        ready_nx    = 1'b1;
        init_finish = 1'b1;
        st_nx       = ST_IDLE;
      end
      ST_IDLE: if (ref_req && ref_grant) begin
        cmd_nx   = CMD_PALL;
        gap_load = 1'b1;
        gap_val  = TW'(TRP_CYC - 1);
        ready_nx = 1'b0;
        grant_ok = 1'b1;
        st_nx    = ST_RF_REF;
      end
      ST_RF_REF: if (gap_done) begin
        cmd_nx    = CMD_REF;
        ref_issue = 1'b1;
        gap_load  = 1'b1;
        gap_val   = TW'(TRC_CYC - 1);
        st_nx     = ST_RF_WAIT;
      end
      ST_RF_WAIT: if (gap_done) begin
        ready_nx = 1'b1;
        st_nx    = ST_IDLE;
      end
      default: st_nx = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_PAUSE;
      ref_cnt <= '0;
      ready   <= 1'b0;
    end else begin
      st      <= st_nx;
      ref_cnt <= ref_cnt_nx;
      ready   <= ready_nx;
    end
  end

  sdram_gap_timer #(
    .W    (TW),
    .INIT (TW'(PAUSE_CYC))
  ) i_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (gap_load),
    .load_val (gap_val),
    .done     (gap_done)
  );

  sdram_ref_interval #(
    .W      (IW),
    .RELOAD (IW'(REFI_CYC - 1))
  ) i_interval (
    .clk    (clk),
    .rst    (rst),
    .reload (ref_issue),
    .allow  (ready),
    .clear  (grant_ok),
    .req    (ref_req)
  );

  sdram_cmd_drive #(
    .AW        (AW),
    .BW        (BW),
    .DW        (DW),
    .MODE_WORD (MODE_WORD)
  ) i_drive (
    .clk         (clk),
    .rst         (rst),
    .cmd         (cmd_nx),
    .dqm_release (init_finish),
    .cke         (cke),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ba          (ba),
    .addr        (addr),
    .dqm         (dqm)
  );

  assert_req_needs_grant_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_req) |-> $past(ref_grant));

  assert_dqm_release_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(dqm[0]) |-> ready);

  assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    ready |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

  assert_idle_stays_R10: assert property (@(posedge clk) disable iff (rst)
    (ready && !ref_req) |=> ready);

endmodule

// File: tb/test_sdram_pwrup_seq.sv
module test_sdram_pwrup_seq;

  // expected cycle counts at a 4 ns clock, taken from the requirements
  localparam int PAUSE_EXP = 100;   // 400 ns pause
  localparam int TRC_EXP   = 17;    // 67.5 ns rounded up (R7)
  localparam int TRP_EXP   = 5;     // 20 ns exact (R7)
  localparam int REFI_EXP  = 500;   // 2 us interval
  localparam int MRD_EXP   = 2;

  typedef struct {
    int          kind;
    int          cyc;
    logic [11:0] addr;
    string       req;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_grant = 1'b0;
  logic        ready, ref_req, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [3:0]  dqm;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  ev_t exp_q[$];

  always #2 clk = ~clk;

  sdram_pwrup_seq #(
    .CLK_PERIOD_PS (4000),
    .PAUSE_PS      (400_000),
    .TRC_PS        (67_500),
    .TRP_PS        (20_000),
    .REFI_PS       (2_000_000),
    .TMRD_CYC      (2),
    .INIT_REFS     (8),
    .MODE_WORD     (10'h032)
  ) i_sdram_pwrup_seq (
    .clk (clk), .rst (rst), .ref_grant (ref_grant), .ready (ready),
    .ref_req (ref_req), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr), .dqm (dqm)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // R11 encodings: NOP 0111, precharge 0010, REF 0001, MRS 0000
  function automatic int decode(input logic [3:0] p);
    case (p)
      4'b0111: return 0;
      4'b0010: return 1;
      4'b0001: return 2;
      4'b0000: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic push(input int k, input int t, input logic [11:0] a, input string r);
    ev_t e;
    e.kind = k; e.cyc = t; e.addr = a; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // scoreboard monitor: every non-NOP command is matched against the queue
  always @(negedge clk) begin
    int  k;
    ev_t e;
    if (!rst && !finished) begin
      k = decode({cs_n, ras_n, cas_n, we_n});
      if (k != 0) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected command", k, 0);
        end else begin
          e = exp_q.pop_front();
          chk(k == e.kind, "R11", "command kind", k, e.kind);
          chk(cyc == e.cyc, e.req, "command cycle", cyc, e.cyc);
          chk({ba, addr} == {2'b00, e.addr}, e.req, "bank/address", {ba, addr}, e.addr);
        end
      end
      chk(cke == 1'b1, "R2", "cke high", cke, 1);
    end
  end

  initial begin
    int t, last_ref, mrs_t, c, ref1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "reset pins", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(cke == 1'b1 && dqm == 4'hF, "R1", "reset cke/dqm", {cke, dqm}, 5'h1F);
    chk(!ready && !ref_req, "R1", "reset flags", {ready, ref_req}, 0);
    rst = 1'b0;

    // R3 R4 R5 R7 init sequence
    t = PAUSE_EXP + 1;
    push(1, t, 12'h400, "R3");
    t += TRP_EXP;
    last_ref = t;
    for (int i = 0; i < 8; i++) begin
      push(2, t, 12'h000, (i == 0) ? "R7" : "R4");
      last_ref = t;
      t += TRC_EXP;
    end
    mrs_t = t;
    push(3, mrs_t, 12'h032, "R5");

    while (cyc < mrs_t + MRD_EXP - 1) @(negedge clk);
    chk(dqm == 4'hF && !ready, "R2", "dqm held before ready", {ready, dqm}, 4'hF);
    @(negedge clk);
    chk(ready == 1'b1 && cyc == mrs_t + MRD_EXP, "R6", "ready rise cycle", cyc, mrs_t + MRD_EXP);
    chk(dqm == 4'h0, "R2", "dqm released", dqm, 0);

    // R10 grant without request
    ref_grant = 1'b1;
    repeat (3) @(negedge clk);
    ref_grant = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && ref_req == 1'b0, "R10", "grant w/o request", {ready, ref_req}, 2'b10);

    // R8 request timing and hold
    while (!ref_req) @(negedge clk);
    chk(cyc == last_ref + REFI_EXP, "R8", "request rise cycle", cyc, last_ref + REFI_EXP);
    repeat (10) @(negedge clk);
    chk(ref_req == 1'b1 && ready == 1'b1, "R8", "request held", {ref_req, ready}, 2'b11);

    // R9 late grant
    c = cyc;
    ref_grant = 1'b1;
    push(1, c + 1, 12'h400, "R9");
    push(2, c + 1 + TRP_EXP, 12'h000, "R9");
    ref1 = c + 1 + TRP_EXP;
    @(negedge clk);
    ref_grant = 1'b0;
    chk(!ready && !ref_req && cyc == c + 1, "R9", "ready/req fall", {ready, ref_req}, 0);
    while (!ready) @(negedge clk);
    chk(cyc == ref1 + TRC_EXP, "R9", "ready return cycle", cyc, ref1 + TRC_EXP);

    // R8 R9 grant held high ahead of the request
    ref_grant = 1'b1;
    while (!ref_req) @(negedge clk);
    chk(cyc == ref1 + REFI_EXP, "R8", "reload from REF", cyc, ref1 + REFI_EXP);
    push(1, cyc + 1, 12'h400, "R9");
    push(2, cyc + 1 + TRP_EXP, 12'h000, "R9");
    t = cyc + 1 + TRP_EXP;
    @(negedge clk);
    chk(!ref_req && !ready, "R9", "held grant accepted", {ref_req, ready}, 0);
    while (!ready) @(negedge clk);
    ref_grant = 1'b0;
    chk(cyc == t + TRC_EXP, "R9", "ready after held grant", cyc, t + TRC_EXP);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "expected commands left", exp_q.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule